// File: doc/BRIEF.md
# Two-Input Pulse Arrival Interval Meter

The block watches two pulse inputs, A and B, and measures how long after one input rises the other becomes high. Two mirrored counting engines run side by side: one is armed by a rising edge on A and stopped by B being high. The other is armed by B and stopped by A. Both inputs are first brought into the clock domain by two-flop synchronisers, and rising edges are found on the synchronised levels.

An engine loads a down-counter with all ones when it arms. It takes one step every `STEP_CYCLES` clocks. When the stopping input is seen high, the engine reports the bitwise inverse of the counter, which is the number of whole steps taken. If the stopping input is already high when the arming edge is seen, the engine reports zero at once. An engine that reaches the programmable step limit without seeing its stop input drops the measurement, pulses a timeout flag and returns to waiting.

Each result carries a direction tag and goes into a small result queue. Results leave the queue on a valid/ready stream. `res_valid` stays high with stable `res_dir` and `res_count` until `res_ready` takes the item. Back-pressure never reaches the engines: when the queue is full, a new result is dropped and the engines carry on.

Top module: `pulse_gap_meter`

## Requirements
- R1: Each input passes through a two-flop synchroniser. An engine arms only on a rising edge of its synchronised input, so an input held high yields exactly one measurement.
- R2: The A-armed engine, when B's synchronised level first reads high N cycles (N >= 1) after A's synchronised edge, reports a count of floor((N-1)/STEP_CYCLES), with STEP_CYCLES = 3 by default.
- R3: If the stopping input is already high in the cycle the arming edge is seen, the engine reports a count of 0.
- R4: The B-armed engine mirrors R2 and R3 with A and B swapped. `res_dir` is 0 for results of the A-armed engine and 1 for results of the B-armed engine.
- R5: When both synchronised inputs rise in the same cycle, only the A-armed engine reports, with a count of 0. The B-armed engine does not arm.
- R6: When both engines finish in the same cycle, the A-armed result enters the queue first and the B-armed result enters in the next cycle.
- R7: A result that arrives while the queue holds DEPTH (default 4) items is discarded. Items already queued are kept in order, and later results are accepted once space frees.
- R8: An engine whose step count reaches `timeout_limit` without its stop input high produces no result. It pulses its bit of `timeout_flag` (bit 0 for the A-armed engine, bit 1 for the B-armed engine) for one cycle and re-arms. A stop seen in the cycle the limit is reached still reports the count.
- R9: After reset `res_valid` and `timeout_flag` are 0.
- R10: Results leave in arrival order. While `res_valid` is high and `res_ready` is low, `res_valid`, `res_dir` and `res_count` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_a | input | 1 | Asynchronous pulse input A |
| pulse_b | input | 1 | Asynchronous pulse input B |
| timeout_limit | input | CNT_W | Step count at which a waiting engine gives up |
| timeout_flag | output | 2 | One-cycle pulse per engine on timeout (bit 0 A-armed, bit 1 B-armed) |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_dir | output | 1 | 0: A-armed engine, 1: B-armed engine |
| res_count | output | CNT_W | Measured step count |

## Verification
A then B is driven with several gaps that land on both sides of step boundaries (1, 2, 3, 4, 7, 10 cycles), then B then A, then simultaneous rises. Each ordering tells apart the counting engine, the immediate-zero engine, the same-edge suppression and the A-first ordering. Gaps of 16 and 17 cycles against a limit of 5 steps separate a stop on the limit step from a timeout. A lone A pulse and a lone B pulse check which timeout bit fires. A stalled consumer with three A-then-B pairs shows that overflow drops only the newest results and that the stream holds its data while stalled.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_COUNT, ENG_DONE} eng_state_e;
  localparam logic DIR_A = 1'b0;
  localparam logic DIR_B = 1'b1;
endpackage

// File: rtl/pgm_sync.sv
module pgm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[1:0], din};
  end

  assign level = shreg[1];
  assign rise  = shreg[1] & ~shreg[2];
endmodule

// File: rtl/pgm_engine.sv
module pgm_engine
  import pgm_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int STEP_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_rise,
  input  logic             stop_level,
  input  logic             inhibit,
  input  logic [CNT_W-1:0] limit,
  input  logic             take,
  output logic             valid,
  output logic             busy,
  output logic [CNT_W-1:0] count,
  output logic             timeout
);
  localparam int PH_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_CYCLES - 1);

  eng_state_e       state;
  logic [CNT_W-1:0] down;
  logic [PH_W-1:0]  phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      down    <= '1;
      phase   <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (arm_rise && !inhibit) begin
            down  <= '1;
            phase <= '0;
            state <= stop_level ? ENG_DONE : ENG_COUNT;
          end
        end
        ENG_COUNT: begin
          if (stop_level) begin
            state <= ENG_DONE;
          end else if (~down == limit) begin
            timeout <= 1'b1;
            state   <= ENG_IDLE;
          end else if (phase == PH_LAST) begin
            phase <= '0;
            down  <= down - 1'b1;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        ENG_DONE: begin
          if (take) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign valid = (state == ENG_DONE);
  assign busy  = (state != ENG_IDLE);
  assign count = ~down;
endmodule

// File: rtl/pgm_queue.sv
module pgm_queue #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;
  logic          full, do_push, do_pop;

  assign full    = (fill == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      fill <= fill + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign out_valid = (fill != '0);
  assign out_data  = mem[rd_ptr];
endmodule

// File: rtl/pulse_gap_meter.sv
module pulse_gap_meter
  import pgm_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int STEP_CYCLES = 3,
  parameter int DEPTH       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_a,
  input  logic             pulse_b,
  input  logic [CNT_W-1:0] timeout_limit,
  output logic [1:0]       timeout_flag,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_dir,
  output logic [CNT_W-1:0] res_count
);
  localparam int QW = CNT_W + 1;

  logic [1:0]       pin;
  logic [1:0]       level, rise;
  logic [1:0]       eng_valid, eng_busy, grant;
  logic [CNT_W-1:0] eng_cnt [2];
  logic             push;
  logic [QW-1:0]    push_data, q_data;

  assign pin = {pulse_b, pulse_a};

  for (genvar i = 0; i < 2; i++) begin : g_ch
    pgm_sync u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin[i]),
      .level(level[i]), .rise(rise[i])
    );

    pgm_engine #(.CNT_W(CNT_W), .STEP_CYCLES(STEP_CYCLES)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .arm_rise(rise[i]),
      .stop_level(level[1-i]),
      .inhibit((i == 1) ? rise[0] : 1'b0),
      .limit(timeout_limit),
      .take(grant[i]),
      .valid(eng_valid[i]),
      .busy(eng_busy[i]),
      .count(eng_cnt[i]),
      .timeout(timeout_flag[i])
    );
  end

  // A-armed engine has priority; the other waits one cycle in its done state
  assign grant[0]  = eng_valid[0];
  assign grant[1]  = eng_valid[1] & ~eng_valid[0];
  assign push      = |grant;
  assign push_data = grant[0] ? {DIR_A, eng_cnt[0]} : {DIR_B, eng_cnt[1]};

  pgm_queue #(.W(QW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(push_data),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(q_data)
  );

  assign res_dir   = q_data[QW-1];
  assign res_count = q_data[CNT_W-1:0];
endmodule

// File: rtl/pgm_checker.sv
module pgm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_dir,
  input logic [CNT_W-1:0] res_count,
  input logic             rise_a,
  input logic             rise_b,
  input logic             level_b,
  input logic             busy_a,
  input logic             busy_b,
  input logic             valid_a,
  input logic [CNT_W-1:0] cnt_a,
  input logic [1:0]       tmo
);
  AST_HOLD_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_dir) && $stable(res_count)); // R10

  AST_ZERO_AT_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    rise_a && level_b && !busy_a |=> valid_a && cnt_a == '0); // R3

  AST_SAME_EDGE_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rise_a && rise_b && !busy_b |=> !busy_b); // R5

  AST_TMO_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo[0] |-> !valid_a); // R8

  AST_TMO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo[1] |=> !tmo[1]); // R8
endmodule

bind pulse_gap_meter pgm_checker #(.CNT_W(CNT_W)) u_pgm_checker (
  .clk(clk), .rst_n(rst_n),
  .res_valid(res_valid), .res_ready(res_ready),
  .res_dir(res_dir), .res_count(res_count),
  .rise_a(rise[0]), .rise_b(rise[1]), .level_b(level[1]),
  .busy_a(eng_busy[0]), .busy_b(eng_busy[1]),
  .valid_a(eng_valid[0]), .cnt_a(eng_cnt[0]),
  .tmo(timeout_flag)
);

// File: tb/test_pulse_gap_meter.sv
`timescale 1ns/1ps
module test_pulse_gap_meter;
  localparam int CNT_W = 32;
  localparam int STEP  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse_a = 1'b0, pulse_b = 1'b0;
  logic [CNT_W-1:0] timeout_limit = 32'd100;
  logic [1:0]       timeout_flag;
  logic             res_valid, res_ready = 1'b1, res_dir;
  logic [CNT_W-1:0] res_count;

  int errors = 0, checks = 0, tmo_a = 0, tmo_b = 0;
  logic [CNT_W:0] exp_q [$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_gap_meter #(.CNT_W(CNT_W), .STEP_CYCLES(STEP), .DEPTH(4)) i_pulse_gap_meter (
    .clk(clk), .rst_n(rst_n), .pulse_a(pulse_a), .pulse_b(pulse_b),
    .timeout_limit(timeout_limit), .timeout_flag(timeout_flag),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_dir(res_dir), .res_count(res_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic expect_res(input bit dir, input int cnt, input bit keep);
    if (keep) exp_q.push_back({dir, CNT_W'(cnt)});
  endtask

  // gap > 0: A leads by gap cycles; gap < 0: B leads; gap == 0: together
  task automatic run_pair(input int gap, input bit keep);
    int m;
    tick(1);
    if (gap == 0) begin
      expect_res(1'b0, 0, keep);
      pulse_a = 1'b1; pulse_b = 1'b1;
    end else if (gap > 0) begin
      expect_res(1'b0, (gap - 1) / STEP, keep);
      expect_res(1'b1, 0, keep);
      pulse_a = 1'b1; tick(gap); pulse_b = 1'b1;
    end else begin
      m = -gap;
      expect_res(1'b0, 0, keep);
      expect_res(1'b1, (m - 1) / STEP, keep);
      pulse_b = 1'b1; tick(m); pulse_a = 1'b1;
    end
    tick(12);
    pulse_a = 1'b0; pulse_b = 1'b0;
    tick(12);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (timeout_flag[0]) tmo_a++;
      if (timeout_flag[1]) tmo_b++;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected result", {res_dir, res_count}, -1);
        end else begin
          logic [CNT_W:0] e;
          e = exp_q.pop_front();
          check({res_dir, res_count} == e, "R2/R3/R4/R5/R6 result {dir,count}",
                {res_dir, res_count}, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CNT_W:0] held;
    tick(3);
    check(res_valid == 1'b0, "R9 res_valid in reset", res_valid, 0);
    check(timeout_flag == 2'b00, "R9 timeout_flag in reset", timeout_flag, 0);
    rst_n = 1'b1;
    tick(3);
    check(res_valid == 1'b0, "R9 res_valid after reset", res_valid, 0);

    // R2 R4 R6: A leads across step boundaries
    run_pair(1, 1'b1); run_pair(2, 1'b1); run_pair(3, 1'b1);
    run_pair(4, 1'b1); run_pair(7, 1'b1); run_pair(10, 1'b1);
    // R4 R3: B leads
    run_pair(-5, 1'b1); run_pair(-9, 1'b1);
    // R5: simultaneous
    run_pair(0, 1'b1);
    check(exp_q.size() == 0, "R10 queue drained in order", exp_q.size(), 0);

    // R8: limit step boundary
    timeout_limit = 32'd5;
    run_pair(16, 1'b1);
    check(tmo_a == 0, "R8 stop on limit step reports", tmo_a, 0);
    tick(1);
    exp_q.push_back({1'b1, CNT_W'(0)});
    pulse_a = 1'b1; tick(17); pulse_b = 1'b1; tick(12);
    pulse_a = 1'b0; pulse_b = 1'b0; tick(12);
    check(tmo_a == 1, "R8 A-armed timeout flag", tmo_a, 1);
    // lone pulses
    pulse_a = 1'b1; tick(4); pulse_a = 1'b0; tick(40);
    check(tmo_a == 2, "R8 lone A pulse times out", tmo_a, 2);
    pulse_b = 1'b1; tick(4); pulse_b = 1'b0; tick(40);
    check(tmo_b == 1, "R8 lone B pulse sets bit 1", tmo_b, 1);
    check(exp_q.size() == 0 && !res_valid, "R8 no result on timeout", exp_q.size(), 0);
    timeout_limit = 32'd100;

    // R7 R10: stalled consumer, overflow
    res_ready = 1'b0;
    run_pair(4, 1'b1); run_pair(7, 1'b1); run_pair(10, 1'b0);
    check(res_valid == 1'b1, "R10 valid held while stalled", res_valid, 1);
    held = {res_dir, res_count};
    tick(5);
    check({res_dir, res_count} == held, "R10 data stable while stalled", {res_dir, res_count}, held);
    check(held == {1'b0, CNT_W'(1)}, "R7 oldest item kept", held, {1'b0, CNT_W'(1)});
    res_ready = 1'b1;
    tick(10);
    check(exp_q.size() == 0 && !res_valid, "R7 newest results dropped", exp_q.size(), 0);
    run_pair(13, 1'b1);
    tick(10);
    check(exp_q.size() == 0, "R7 accepts after space frees; R1 one result per edge",
          exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule